// File: doc/BRIEF.md
# Parallel Capture Front End with Selectable Sync Edge

This block sits between an external parallel data source and the on-chip event-detection and capture logic. The source supplies a data word and a data-synchronous clock on one fixed input line. The block resamples both into the system clock domain. It detects the configured edge of the sync line and latches the data word on each such edge.

Downstream logic is handed a one-cycle strobe on every second detected word, so the strobe runs at half the incoming transfer rate. The block also presents the most recently latched word.

A separate init input line has a programmable active level. While that line is at its active level, all downstream outputs are forced low and the half-rate phase is cleared. The phase therefore restarts cleanly when the line is released. A one-byte control register holds three fields: the edge choice, the init polarity and an enable. The data width is fixed at build time to 8 or 16 bits.

Top module: `pcap_front`

## Requirements
- R1: After reset the control register reads 8'h00, and both `strobe_out` and `data_out` are 0.
- R2: Control register layout: bit 0 selects the sync edge (0 rising, 1 falling), bit 2 selects the active init level (0 low, 1 high), and bit 3 enables the block. Bits 1 and 4 to 7 always read 0, so writing 8'hFF reads back 8'h0D.
- R3: Bits 0 and 2 take a written value only when `blk_rst` is 0; a write while `blk_rst` is 1 leaves them unchanged. Bit 3 takes its written value at any time.
- R4: With the block enabled and init inactive, each edge of `sync_in` in the selected direction is a detected edge. `strobe_out` pulses high for exactly one clock on the 1st, 3rd, 5th and later odd detected edges after the block was last active-released. Each pulse comes within 3 clocks of the edge.
- R5: `data_out` shows the word that was on `data_in` at the latest detected edge. `data_in` must be held stable for at least 2 clocks before and after that edge. While `strobe_out` is high, `data_out` carries that strobe's word.
- R6: A `sync_in` edge in the non-selected direction produces no strobe and leaves `data_out` unchanged.
- R7: While the synchronized `init_in` equals control bit 2, `strobe_out` and `data_out` are 0. No word is captured during that time. The half-rate phase is cleared, so the first detected edge after release gives a strobe.
- R8: While control bit 3 is 0, `strobe_out` and `data_out` are 0 and the half-rate phase is cleared. The first detected edge after enabling gives a strobe.
- R9: Parameter `DATA_W` may be 8 or 16, and `data_in`/`data_out` are `DATA_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_rst | input | 1 | Block-level reset control bit; while 1, edge and level fields are locked |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| sync_in | input | 1 | External data-synchronous clock (asynchronous) |
| init_in | input | 1 | External init line (asynchronous) |
| data_in | input | DATA_W | External parallel data word |
| strobe_out | output | 1 | Half-rate strobe to downstream units |
| data_out | output | DATA_W | Latest captured word to downstream units |

## Verification
The hardest case to reach is an init pulse that lands while the half-rate phase sits at its odd position, after exactly one word has been taken. Only a cleared phase then makes the first word after release strobe. The stimulus sends a single word, raises the init line, offers a word that must be ignored, releases the line, and sends one more word. Both the count of strobes and the data carried by the last strobe are then checked. The same restart is repeated through the enable bit and under the opposite init polarity.

// File: rtl/pcap_front.sv
module pcap_front #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              sync_in,
  input  logic              init_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              strobe_out,
  output logic [DATA_W-1:0] data_out
);

  logic              edge_fall, init_hi, run_en;
  logic              sync_m, sync_s, sync_p;
  logic              init_m, init_s;
  logic [DATA_W-1:0] data_m, data_s, hold;
  logic              tog, stb;
  logic              edge_det, init_act, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_fall <= 1'b0;
      init_hi   <= 1'b0;
      run_en    <= 1'b0;
    end else if (cfg_we) begin
      run_en <= cfg_wdata[3];
      if (!blk_rst) begin
        edge_fall <= cfg_wdata[0];
        init_hi   <= cfg_wdata[2];
      end
    end
  end

  assign cfg_rdata = {4'b0000, run_en, init_hi, 1'b0, edge_fall};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sync_m, sync_s, sync_p} <= 3'b000;
      {init_m, init_s}         <= 2'b00;
      data_m <= '0;
      data_s <= '0;
    end else begin
      {sync_m, sync_s, sync_p} <= {sync_in, sync_m, sync_s};
      {init_m, init_s}         <= {init_in, init_m};
      data_m <= data_in;
      data_s <= data_m;
    end
  end

  assign edge_det = edge_fall ? (sync_p & ~sync_s) : (~sync_p & sync_s);
  assign init_act = (init_s == init_hi);
  assign active   = run_en & ~init_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      tog  <= 1'b0;
      stb  <= 1'b0;
    end else if (!active) begin
      hold <= '0;
      tog  <= 1'b0;
      stb  <= 1'b0;
    end else if (edge_det) begin
      hold <= data_s;
      tog  <= ~tog;
      stb  <= ~tog;
    end else begin
      stb  <= 1'b0;
    end
  end

  assign strobe_out = stb & active;
  assign data_out   = active ? hold : '0;

  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |=> !strobe_out);

  assert_strobe_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_out |-> tog);

  assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && blk_rst) |=> ($stable(edge_fall) && $stable(init_hi)));

  assert_init_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && init_act) |=> (!tog && hold == '0));

  assert_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!tog && !strobe_out));

  assert_ignore_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !edge_det && $past(active)) |=> (!stb));

endmodule

// File: tb/pcap_front_tb.sv
module pcap_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata, cfg_rdata8;
  logic        sync_in = 1'b0;
  logic        init_in = 1'b0;
  logic [15:0] data_in = 16'h0000;
  logic        strobe_out, strobe8;
  logic [15:0] data_out;
  logic [7:0]  data8;

  always #4 clk = ~clk;

  pcap_front #(.DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .blk_rst(blk_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sync_in(sync_in),
    .init_in(init_in), .data_in(data_in), .strobe_out(strobe_out),
    .data_out(data_out));

  pcap_front #(.DATA_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .blk_rst(blk_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata8), .sync_in(sync_in),
    .init_in(init_in), .data_in(data_in[7:0]), .strobe_out(strobe8),
    .data_out(data8));

  int checks = 0;
  int errors = 0;
  int ncap = 0;
  int ncap8 = 0;
  logic [15:0] cap [0:7];
  logic [7:0]  cap8 [0:7];
  logic        fall_mode = 1'b0;

  // fall, w0, w1, w2, w3, expected first strobe word, expected second strobe word
  localparam logic [96:0] VEC [0:5] = '{
    {1'b0, 16'h1234, 16'hABCD, 16'h5A5A, 16'h00FF, 16'h1234, 16'h5A5A},
    {1'b1, 16'hCAFE, 16'h0001, 16'hBEEF, 16'h8000, 16'hCAFE, 16'hBEEF},
    {1'b0, 16'hFFFF, 16'h7777, 16'h0F0F, 16'hF0F0, 16'hFFFF, 16'h0F0F},
    {1'b1, 16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h0102, 16'h0506},
    {1'b0, 16'h8001, 16'h4002, 16'h2004, 16'h1008, 16'h8001, 16'h2004},
    {1'b1, 16'h00A5, 16'hA500, 16'h3C3C, 16'hC3C3, 16'h00A5, 16'h3C3C}
  };

  always @(negedge clk) begin
    if (strobe_out) begin
      if (ncap < 8) cap[ncap] = data_out;
      ncap = ncap + 1;
    end
    if (strobe8) begin
      if (ncap8 < 8) cap8[ncap8] = data8;
      ncap8 = ncap8 + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v, input logic br);
    @(negedge clk);
    blk_rst = br; cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; blk_rst = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    data_in = w;
    repeat (3) @(negedge clk);
    sync_in = ~fall_mode;
    repeat (4) @(negedge clk);
    sync_in = fall_mode;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input logic [7:0] v);
    wr(v & 8'hF7, 1'b0);
    fall_mode = v[0];
    sync_in = v[0];
    repeat (6) @(negedge clk);
    wr(v, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 cfg in reset", cfg_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cfg_rdata == 8'h00, "R1 cfg after reset", cfg_rdata, 8'h00);
    chk(strobe_out == 1'b0, "R1 strobe", strobe_out, 0);
    chk(data_out == 16'h0, "R1 data", data_out, 0);

    wr(8'hFF, 1'b0);
    chk(cfg_rdata == 8'h0D, "R2 reserved bits", cfg_rdata, 8'h0D);
    chk(cfg_rdata8 == 8'h0D, "R2 reserved bits w8", cfg_rdata8, 8'h0D);
    wr(8'h00, 1'b1);
    chk(cfg_rdata == 8'h05, "R3 locked fields", cfg_rdata, 8'h05);
    wr(8'h08, 1'b1);
    chk(cfg_rdata == 8'h0D, "R3 enable while locked", cfg_rdata, 8'h0D);
    wr(8'h00, 1'b0);
    chk(cfg_rdata == 8'h00, "R3 unlocked write", cfg_rdata, 8'h00);

    for (int i = 0; i < 6; i++) begin
      set_mode({4'b0000, 1'b1, 1'b1, 1'b0, VEC[i][96]});
      ncap = 0; ncap8 = 0;
      send_word(VEC[i][95:80]);
      send_word(VEC[i][79:64]);
      send_word(VEC[i][63:48]);
      send_word(VEC[i][47:32]);
      chk(ncap == 2, "R4 half-rate strobe count", ncap, 2);
      chk(cap[0] == VEC[i][31:16], "R5 first strobe word", cap[0], VEC[i][31:16]);
      chk(cap[1] == VEC[i][15:0], "R5 second strobe word", cap[1], VEC[i][15:0]);
      chk(data_out == VEC[i][47:32], "R6 word kept over opposite edge", data_out, VEC[i][47:32]);
      chk(ncap8 == 2 && cap8[1] == VEC[i][7:0], "R9 8-bit width", cap8[1], VEC[i][7:0]);
    end

    set_mode(8'h0C);
    ncap = 0;
    send_word(16'h1111);
    chk(ncap == 1, "R4 first word strobes", ncap, 1);
    chk(data_out == 16'h1111, "R5 data held", data_out, 16'h1111);
    init_in = 1'b1;
    repeat (6) @(negedge clk);
    chk(data_out == 16'h0, "R7 data low in init", data_out, 0);
    send_word(16'h2222);
    chk(ncap == 1, "R7 no strobe in init", ncap, 1);
    chk(data_out == 16'h0, "R7 no capture in init", data_out, 0);
    init_in = 1'b0;
    repeat (6) @(negedge clk);
    send_word(16'h3333);
    chk(ncap == 2, "R7 phase restart after init", ncap, 2);
    chk(cap[1] == 16'h3333, "R7 restart word", cap[1], 16'h3333);

    set_mode(8'h08);
    ncap = 0;
    send_word(16'h4444);
    chk(ncap == 0 && data_out == 16'h0, "R7 low-active init holds", ncap, 0);
    init_in = 1'b1;
    repeat (6) @(negedge clk);
    send_word(16'h5555);
    chk(ncap == 1 && cap[0] == 16'h5555, "R7 low-active release", cap[0], 16'h5555);

    ncap = 0;
    wr(8'h00, 1'b0);
    repeat (4) @(negedge clk);
    send_word(16'h6666);
    send_word(16'h7777);
    chk(ncap == 0, "R8 no strobe when disabled", ncap, 0);
    chk(data_out == 16'h0, "R8 data low when disabled", data_out, 0);
    wr(8'h08, 1'b0);
    repeat (6) @(negedge clk);
    send_word(16'h8888);
    chk(ncap == 1 && cap[0] == 16'h8888, "R8 restart after enable", cap[0], 16'h8888);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule